// File: doc/BRIEF.md
# Integer to Single-Precision Converter

This block takes a signed two's-complement integer and produces its IEEE-754 single-precision value. The value is placed in the lowest 32-bit lane of a 128-bit vector register image. The caller supplies the old contents of the destination register as `dest_in`, and the upper 96 bits of that image pass through to the output unchanged. A mode input chooses the source width. In narrow mode only the low 32 bits of the source are used. In wide mode all 64 bits are used.

A 2-bit field selects the rounding mode for results that cannot be represented exactly. Any such inexact conversion sets a sticky precision flag, which stays set until an explicit clear input is applied. A mask input decides what an inexact result does. When the exception is masked, the rounded value is written. When it is unmasked, the destination image is returned untouched and a fault pulse is raised instead.

The datapath is one combinational path: sign and magnitude, leading-zero count, normalising shift, then rounding. The output stage is registered. Each accepted input produces a one-cycle `out_valid` pulse on the following clock.

Top module: `int2sp_merge`

## Requirements
- R1: When `wide_sel`=0, the source is `int_src[31:0]` sign-extended, and `int_src[63:32]` has no effect on any output.
- R2: When `wide_sel`=1, the source is the full 64-bit `int_src`.
- R3: The result is written to `out_vec[31:0]` as sign in bit 31, exponent biased by 127 in bits 30:23, and fraction in bits 22:0. `out_vec[127:32]` equals `dest_in[127:32]` of the same operation.
- R4: `rmode` selects the rounding: 00 rounds to nearest with ties to even, 01 rounds toward minus infinity, 10 rounds toward plus infinity, and 11 truncates toward zero.
- R5: A zero source gives +0.0 (all 32 bits zero). The most negative source gives exactly -2^31 (0xCF000000) or -2^63 (0xDF000000).
- R6: For an inexact conversion with `prec_mask`=1, the rounded result is written and `out_fault` stays 0.
- R7: For an inexact conversion with `prec_mask`=0, `out_vec` equals `dest_in` in full and `out_fault` pulses 1 together with `out_valid`.
- R8: `prec_flag` rises on the clock that registers an inexact conversion, whatever the mask. Exact conversions leave it set. `flag_clr` clears it, but an inexact conversion in the same cycle as the clear leaves it set.
- R9: `out_valid` is high for exactly one cycle, on the clock after each `in_valid` cycle. When no conversion is accepted, `out_vec` holds its value.
- R10: While `rst_n` is low at a clock edge, `out_valid`, `out_fault`, `prec_flag` and `out_vec` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Conversion request this cycle |
| wide_sel | input | 1 | 1 = 64-bit source, 0 = 32-bit source |
| int_src | input | 64 | Signed integer source |
| dest_in | input | 128 | Previous destination register image |
| rmode | input | 2 | Rounding mode select |
| prec_mask | input | 1 | 1 = precision exception masked |
| flag_clr | input | 1 | Clears the sticky precision flag |
| out_valid | output | 1 | Result valid pulse |
| out_vec | output | 128 | Merged destination image |
| out_fault | output | 1 | Unmasked precision exception pulse |
| prec_flag | output | 1 | Sticky precision flag |

## Verification
The bench goes after exact rounding ties such as 2^24+1 and 2^24+3. A design that ignored the even-LSB rule, or that folded the round bit into sticky, would land one ULP off on these values. It also drives the all-ones significand case 0x7FFFFFFF. A rounding carry that is mishandled there would give 0x4E800000 or a garbage exponent instead of 0x4F000000.

The most negative integers in both widths are driven, where a magnitude path that overflows would give the wrong sign or exponent. Narrow-mode operands are driven with junk in the upper word, which catches a design that ignores the width select. Unmasked inexact cases are checked to return the old image in full. Clear and set are applied in the same cycle, which catches a flag whose clear wins over a new event.

// File: rtl/int2sp_pkg.sv
// Package: shared types and format constants for the integer to
// single-precision converter. Assumes an 8-bit exponent and 23-bit fraction.
package int2sp_pkg;
    localparam int SP_MAN_W = 23;
    localparam int SP_EXP_W = 8;
    localparam int SP_BIAS  = 127;
    localparam int SP_SIG_W = SP_MAN_W + 1;
    localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'b00,
        RND_DOWN    = 2'b01,
        RND_UP      = 2'b10,
        RND_ZERO    = 2'b11
    } rnd_mode_e;

    // Normalised operand before rounding
    typedef struct packed {
        logic                sign;
        logic                zero;
        logic [SP_EXP_W-1:0] exp;
        logic [SP_SIG_W-1:0] sig;
        logic                guard;
        logic                rnd;
        logic                sticky;
    } norm_t;
endpackage

// File: rtl/int2sp_lzc.sv
// Leading-zero counter: returns the number of zero bits above the highest
// set bit of vec, or W when vec is zero. Purely combinational.
module int2sp_lzc #(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [CNT_W-1:0] cnt
);
    // Scan upward so the highest set bit decides the count
    always_comb begin
        cnt = CNT_W'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CNT_W'(W - 1 - i);
        end
    end
endmodule

// File: rtl/int2sp_norm.sv
// Normaliser: picks the source width, forms sign and magnitude, and shifts
// the magnitude so its top set bit sits at the MSB. It then extracts the
// 24-bit significand plus guard, round and sticky bits.
// Assumes the biased exponent of INT_W-1 fits in SP_EXP_W bits.
module int2sp_norm
    import int2sp_pkg::*;
#(
    parameter int INT_W    = 64,
    parameter int NARROW_W = 32
) (
    input  logic             wide_sel,
    input  logic [INT_W-1:0] int_src,
    output norm_t            norm
);
    localparam int CNT_W   = $clog2(INT_W + 1);
    localparam int EXP_TOP = SP_BIAS + INT_W - 1;
    localparam int G_POS   = INT_W - SP_SIG_W - 1;

    logic [INT_W-1:0] ext;
    logic [INT_W-1:0] mag;
    logic [INT_W-1:0] shifted;
    logic [CNT_W-1:0] lz;

    // Width selection: sign-extend the narrow operand when one exists
    generate
        if (INT_W > NARROW_W) begin : g_sel
            always_comb ext = wide_sel ? int_src
                : {{(INT_W-NARROW_W){int_src[NARROW_W-1]}}, int_src[NARROW_W-1:0]};
        end else begin : g_fixed
            always_comb ext = int_src;
        end
    endgenerate

    // Magnitude; the most negative value wraps to itself, which is correct unsigned
    always_comb mag = ext[INT_W-1] ? (~ext + INT_W'(1)) : ext;

    int2sp_lzc #(.W(INT_W), .CNT_W(CNT_W)) u_lzc (
        .vec (mag),
        .cnt (lz)
    );

    // Shift, slice significand and collect the bits below it
    always_comb begin
        shifted     = mag << lz;
        norm.sign   = ext[INT_W-1];
        norm.zero   = (mag == '0);
        norm.exp    = SP_EXP_W'(EXP_TOP - int'(lz));
        norm.sig    = shifted[INT_W-1 -: SP_SIG_W];
        norm.guard  = shifted[G_POS];
        norm.rnd    = shifted[G_POS-1];
        norm.sticky = |shifted[G_POS-2:0];
    end
endmodule

// File: rtl/int2sp_round.sv
// Rounding unit: applies the selected rounding mode to the normalised
// significand, handles the carry out of the significand, and packs the
// single-precision word. Assumes the exponent cannot overflow.
module int2sp_round
    import int2sp_pkg::*;
(
    input  norm_t           norm,
    input  logic [1:0]      rmode,
    output logic [SP_W-1:0] result,
    output logic            inexact
);
    logic                  inc;
    logic                  carry;
    logic [SP_SIG_W:0]     sum;
    logic [SP_MAN_W-1:0]   frac;
    logic [SP_EXP_W-1:0]   exp_o;
    rnd_mode_e             mode;

    // Increment decision per rounding mode
    always_comb begin
        mode    = rnd_mode_e'(rmode);
        inexact = norm.guard | norm.rnd | norm.sticky;
        unique case (mode)
            RND_NEAREST: inc = norm.guard & (norm.rnd | norm.sticky | norm.sig[0]);
            RND_DOWN:    inc = norm.sign & inexact;
            RND_UP:      inc = ~norm.sign & inexact;
            default:     inc = 1'b0;
        endcase
    end

    // Add, renormalise on carry, and pack
    always_comb begin
        sum    = {1'b0, norm.sig} + {{SP_SIG_W{1'b0}}, inc};
        carry  = sum[SP_SIG_W];
        frac   = carry ? sum[SP_MAN_W:1] : sum[SP_MAN_W-1:0];
        exp_o  = norm.exp + {{(SP_EXP_W-1){1'b0}}, carry};
        result = norm.zero ? '0 : {norm.sign, exp_o, frac};
    end
endmodule

// File: rtl/int2sp_merge.sv
// Top: converts a signed integer (32- or 64-bit) to single precision and
// merges it into the low lane of a vector image. Output stage is registered
// with a one-cycle valid pulse. Keeps a sticky precision flag, and returns
// the old image with a fault pulse when an inexact result is unmasked.
// Reset is synchronous, active low.
module int2sp_merge
    import int2sp_pkg::*;
#(
    parameter int INT_W    = 64,
    parameter int NARROW_W = 32,
    parameter int VEC_W    = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             wide_sel,
    input  logic [INT_W-1:0] int_src,
    input  logic [VEC_W-1:0] dest_in,
    input  logic [1:0]       rmode,
    input  logic             prec_mask,
    input  logic             flag_clr,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_vec,
    output logic             out_fault,
    output logic             prec_flag
);
    norm_t           norm;
    logic [SP_W-1:0] result;
    logic            inexact;
    logic            trap;
    logic [VEC_W-1:0] merged;

    int2sp_norm #(.INT_W(INT_W), .NARROW_W(NARROW_W)) u_norm (
        .wide_sel (wide_sel),
        .int_src  (int_src),
        .norm     (norm)
    );

    int2sp_round u_round (
        .norm    (norm),
        .rmode   (rmode),
        .result  (result),
        .inexact (inexact)
    );

    // Lane merge, or pass the old image through on an unmasked exception
    always_comb begin
        trap   = inexact & ~prec_mask;
        merged = trap ? dest_in : {dest_in[VEC_W-1:SP_W], result};
    end

    // Result register and valid/fault pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            out_fault <= in_valid & trap;
            if (in_valid) out_vec <= merged;
        end
    end

    // Sticky precision flag; a new event outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n) prec_flag <= 1'b0;
        else        prec_flag <= (prec_flag & ~flag_clr) | (in_valid & inexact);
    end
endmodule

// File: rtl/int2sp_merge_chk.sv
// Checker: port-level properties of int2sp_merge, attached by bind.
module int2sp_merge_chk #(
    parameter int INT_W    = 64,
    parameter int NARROW_W = 32,
    parameter int VEC_W    = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             wide_sel,
    input logic [INT_W-1:0] int_src,
    input logic [VEC_W-1:0] dest_in,
    input logic             prec_mask,
    input logic             flag_clr,
    input logic             out_valid,
    input logic [VEC_W-1:0] out_vec,
    input logic             out_fault,
    input logic             prec_flag
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));
    assert_upper_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_vec[VEC_W-1:32] == $past(dest_in[VEC_W-1:32]));
    assert_trap_keeps_image_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_fault || out_vec == $past(dest_in)));
    assert_masked_no_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && prec_mask |=> !out_fault);
    assert_fault_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_valid);
    assert_fault_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> prec_flag);
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prec_flag && !flag_clr |=> prec_flag);
    assert_zero_plus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (wide_sel ? (int_src == '0) : (int_src[NARROW_W-1:0] == '0))
        |=> out_vec[31:0] == 32'h0);
endmodule

bind int2sp_merge int2sp_merge_chk #(
    .INT_W(INT_W), .NARROW_W(NARROW_W), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel),
    .int_src(int_src), .dest_in(dest_in), .prec_mask(prec_mask),
    .flag_clr(flag_clr), .out_valid(out_valid), .out_vec(out_vec),
    .out_fault(out_fault), .prec_flag(prec_flag)
);

// File: tb/tb_int2sp_merge.sv
// Scoreboard bench: the driver computes expected images with its own
// arithmetic model and queues them; the monitor compares on each out_valid.
module tb_int2sp_merge;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid, wide_sel, prec_mask, flag_clr;
    logic [63:0]  int_src;
    logic [127:0] dest_in;
    logic [1:0]   rmode;
    logic         out_valid, out_fault, prec_flag;
    logic [127:0] out_vec;

    int n_checks = 0;
    int n_errs   = 0;
    logic model_flag = 1'b0;

    logic [127:0] q_vec[$];
    logic         q_fault[$];
    logic         q_flag[$];
    string        q_tag[$];

    always #10 clk = ~clk;

    int2sp_merge dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide_sel(wide_sel),
        .int_src(int_src), .dest_in(dest_in), .rmode(rmode),
        .prec_mask(prec_mask), .flag_clr(flag_clr), .out_valid(out_valid),
        .out_vec(out_vec), .out_fault(out_fault), .prec_flag(prec_flag)
    );

    task automatic check(input logic ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent model: integer division by a power of two and remainder compare
    function automatic logic [31:0] ref_cvt(input logic wide, input logic [63:0] src,
                                            input logic [1:0] rm, output logic inex);
        logic [63:0] v, mag, q, rem, half;
        logic neg, up;
        int p, sh, e;
        v   = wide ? src : {{32{src[31]}}, src[31:0]};
        neg = v[63];
        mag = neg ? (~v + 64'd1) : v;
        inex = 1'b0;
        if (mag == 64'd0) return 32'h0;
        p = 0;
        for (int i = 0; i < 64; i++) if (mag[i]) p = i;
        e = p + 127;
        if (p <= 23) q = mag << (23 - p);
        else begin
            sh   = p - 23;
            q    = mag >> sh;
            rem  = mag & ((64'd1 << sh) - 64'd1);
            half = 64'd1 << (sh - 1);
            inex = (rem != 64'd0);
            case (rm)
                2'b00:   up = (rem > half) || (rem == half && q[0]);
                2'b01:   up = neg && inex;
                2'b10:   up = !neg && inex;
                default: up = 1'b0;
            endcase
            q = q + {63'd0, up};
            if (q[24]) begin q = q >> 1; e = e + 1; end
        end
        return {neg, 8'(e), q[22:0]};
    endfunction

    task automatic conv(input logic wide, input logic [63:0] src, input logic [1:0] rm,
                        input logic mask, input logic clr, input logic [127:0] dest,
                        input string tag);
        logic inx;
        logic [31:0] r;
        r = ref_cvt(wide, src, rm, inx);
        @(negedge clk);
        in_valid = 1'b1; wide_sel = wide; int_src = src; rmode = rm;
        prec_mask = mask; flag_clr = clr; dest_in = dest;
        model_flag = (clr ? 1'b0 : model_flag) | inx;
        q_vec.push_back((inx && !mask) ? dest : {dest[127:32], r});
        q_fault.push_back(inx && !mask);
        q_flag.push_back(model_flag);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; flag_clr = 1'b0;
        end
    endtask

    // Monitor: pop and compare each result
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (q_vec.size() == 0) check(1'b0, "R9 unexpected out_valid", 128'd1, 128'd0);
            else begin
                logic [127:0] ev; logic ef, eg; string t;
                ev = q_vec.pop_front(); ef = q_fault.pop_front();
                eg = q_flag.pop_front(); t = q_tag.pop_front();
                check(out_vec === ev, {t, " vec"}, out_vec, ev);
                check(out_fault === ef, {t, " R7 fault"}, 128'(out_fault), 128'(ef));
                check(prec_flag === eg, {t, " R8 flag"}, 128'(prec_flag), 128'(eg));
            end
        end
    end

    initial begin
        #(20 * 100000);
        n_errs++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic dummy;
        logic [127:0] held;
        logic [127:0] da = 128'hA5A5_5A5A_0123_4567_89AB_CDEF_FEDC_BA98;
        logic [127:0] db = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
        rst_n = 1'b0; in_valid = 1'b0; wide_sel = 1'b0; int_src = '0;
        dest_in = '0; rmode = 2'b00; prec_mask = 1'b1; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0 && out_fault === 1'b0 && prec_flag === 1'b0,
              "R10 reset controls", 128'({out_valid, out_fault, prec_flag}), 128'd0);
        check(out_vec === '0, "R10 reset vec", out_vec, 128'd0);
        rst_n = 1'b1;

        // Model sanity against hand-computed constants
        check(ref_cvt(1'b0, 64'h8000_0000, 2'b00, dummy) == 32'hCF00_0000, "R5 model -2^31",
              128'(ref_cvt(1'b0, 64'h8000_0000, 2'b00, dummy)), 128'hCF00_0000);
        check(ref_cvt(1'b0, 64'h7FFF_FFFF, 2'b00, dummy) == 32'h4F00_0000, "R4 model RNE",
              128'(ref_cvt(1'b0, 64'h7FFF_FFFF, 2'b00, dummy)), 128'h4F00_0000);
        check(ref_cvt(1'b0, 64'h7FFF_FFFF, 2'b11, dummy) == 32'h4EFF_FFFF, "R4 model RZ",
              128'(ref_cvt(1'b0, 64'h7FFF_FFFF, 2'b11, dummy)), 128'h4EFF_FFFF);

        // Narrow conversions
        conv(1'b0, 64'd1, 2'b00, 1'b1, 1'b0, da, "R3 one");
        conv(1'b0, 64'hFFFF_FFFF, 2'b00, 1'b1, 1'b0, db, "R1 minus one");
        conv(1'b0, 64'hDEAD_BEEF_0000_0005, 2'b00, 1'b1, 1'b0, da, "R1 upper ignored");
        conv(1'b0, 64'hFFFF_FFFF_0000_0000, 2'b01, 1'b1, 1'b0, db, "R5 zero narrow");
        conv(1'b0, 64'h0000_0000_8000_0000, 2'b00, 1'b1, 1'b0, da, "R5 most negative 32");
        idle(2);
        // Wide conversions
        conv(1'b1, 64'h8000_0000_0000_0000, 2'b00, 1'b1, 1'b0, db, "R5 most negative 64");
        conv(1'b1, 64'h0000_0001_0000_0000, 2'b00, 1'b1, 1'b0, da, "R2 2^32");
        conv(1'b1, 64'd0, 2'b10, 1'b1, 1'b0, db, "R5 zero wide");
        conv(1'b1, 64'h0000_0000_0000_1234, 2'b00, 1'b1, 1'b0, da, "R2 small wide");
        idle(1);
        // Rounding: ties, below-half, all-ones significand, negatives
        for (int m = 0; m < 4; m++) begin
            conv(1'b0, 64'h0100_0001, 2'(m), 1'b1, 1'b0, da, "R4 tie even");
            conv(1'b0, 64'h0100_0003, 2'(m), 1'b1, 1'b0, db, "R4 tie odd");
            conv(1'b0, 64'hFEFF_FFFF, 2'(m), 1'b1, 1'b0, da, "R4 negative tie");
            conv(1'b0, 64'h7FFF_FFFF, 2'(m), 1'b1, 1'b0, db, "R4 carry");
            conv(1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 2'(m), 1'b1, 1'b0, da, "R4 wide max");
            conv(1'b1, 64'hFFFF_FFFF_FF00_0001, 2'(m), 1'b1, 1'b0, db, "R4 wide negative");
        end
        idle(1);
        conv(1'b0, 64'h0200_0001, 2'b00, 1'b1, 1'b0, da, "R6 masked inexact");
        idle(1);
        // Clear then exact ops keep it clear
        @(negedge clk); in_valid = 1'b0; flag_clr = 1'b1; model_flag = 1'b0;
        @(negedge clk); flag_clr = 1'b0;
        check(prec_flag === 1'b0, "R8 clear", 128'(prec_flag), 128'd0);
        conv(1'b0, 64'd7, 2'b00, 1'b1, 1'b0, da, "R8 exact no set");
        conv(1'b0, 64'h0200_0001, 2'b10, 1'b0, 1'b0, db, "R7 unmasked inexact");
        conv(1'b0, 64'd8, 2'b00, 1'b0, 1'b0, da, "R8 sticky through exact");
        conv(1'b1, 64'h0000_0000_0100_0001, 2'b01, 1'b0, 1'b1, db, "R8 clear with event");
        conv(1'b0, 64'd9, 2'b00, 1'b1, 1'b1, da, "R8 clear alone");
        idle(3);
        // Hold while idle
        held = out_vec;
        idle(4);
        check(out_vec === held, "R9 hold", out_vec, held);
        check(out_valid === 1'b0, "R9 no pulse idle", 128'(out_valid), 128'd0);
        check(q_vec.size() == 0, "R9 all results seen", 128'(q_vec.size()), 128'd0);
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule